// File: doc/BRIEF.md
# Iterative Shift-Add Vector Rotator

This block turns a signed two-dimensional fixed-point vector through a signed angle. It uses only adders, arithmetic shifters and a short constant table of arctangents. No multipliers are involved.

A command begins with a one-cycle `start` pulse that carries `x_in`, `y_in` and `angle_in`. The block first applies an exact quarter-turn, clockwise or counter-clockwise by the sign of the angle, so that every angle on the full circle is within reach. It then performs one micro-rotation per clock through a single shared datapath. Each micro-rotation turns left or right by an angle whose tangent is a power of two.

When the last micro-rotation completes, `done` pulses and the rotated components appear on `x_out` and `y_out`. The results still carry the aggregate shift-add gain of about 1.6468. Any gain correction is left to the consumer.

Angles use binary radians. A signed code `a` of `ANG_W` bits means `a·π/2^(ANG_W−1)`, so the most negative code is −π and the code `2^(ANG_W−2)` is +π/2. Inside the block, the x/y datapath carries `FRAC_W` extra fraction bits and the angle accumulator carries `ZFRAC_W` extra fraction bits. Both are dropped or unused at the ports.

Top module: `cordic_rotator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy` and `done` are 0 and `x_out`/`y_out` are 0.
- R2: A `start` seen at a rising edge while `busy` is 0 loads the operands, and `busy` reads 1 on the following cycle.
- R3: `done` is high for exactly one cycle, ITERS clock edges after the edge that accepted `start`, and `busy` is 0 in that same cycle.
- R4: A `start` that arrives while `busy` is 1 has no effect: the run length stays ITERS, and the result belongs to the operands of the accepted command.
- R5: With `done` high, `x_out` is within 5 LSB of K·(x·cosθ − y·sinθ) and `y_out` is within 5 LSB of K·(x·sinθ + y·cosθ), where K = Π_{i<ITERS} √(1+2^(−2i)) and no gain correction is applied.
- R6: R5 holds for angle codes across all four quadrants, including the code for −π (most negative value) and the codes for 0 and ±π/2.
- R7: After the quarter-turn correction, the residual angle loaded into the accumulator lies in [−π/2, +π/2].
- R8: While `busy` is 0 and no `start` is accepted, `x_out` and `y_out` keep their values.
- R9: Outputs are `DATA_W+1` bits signed. Any input vector of magnitude up to 39000 (with DATA_W=16), including x = −2^(DATA_W−1), produces results that do not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command pulse, taken only when idle |
| x_in | input | DATA_W | Signed x component of the vector |
| y_in | input | DATA_W | Signed y component of the vector |
| angle_in | input | ANG_W | Signed rotation angle in binary radians |
| busy | output | 1 | High while micro-rotations are running |
| done | output | 1 | One-cycle pulse when the result is valid |
| x_out | output | DATA_W+1 | Rotated x component, gain included |
| y_out | output | DATA_W+1 | Rotated y component, gain included |

## Verification
The embedded assertions check the handshake timing on every cycle: the one-cycle `done`, the gap-free iteration count, that a start is taken only when idle, that the outputs hold while idle, and that the residual after the quarter-turn stays within ±π/2.

The numerical accuracy, the full-circle coverage and the absence of wrap at large magnitudes can be shown only by the bench. It sweeps 128 angles over nine vectors, plus a set of large-magnitude corner vectors. Each result is compared against a real-valued rotation scaled by K. The bench also shows that a start injected mid-run is ignored.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    typedef enum logic [0:0] {
        CR_IDLE = 1'b0,
        CR_RUN  = 1'b1
    } cr_state_e;

    // atan(2^-idx) as an unsigned fraction of pi, scaled by 2^31
    function automatic logic [31:0] atan_brad32(input int unsigned idx);
        logic [31:0] v;
        case (idx)
            0:       v = 32'd536870912;
            1:       v = 32'd316933406;
            2:       v = 32'd167458907;
            3:       v = 32'd85004756;
            4:       v = 32'd42667331;
            5:       v = 32'd21354465;
            6:       v = 32'd10679838;
            7:       v = 32'd5340245;
            8:       v = 32'd2670163;
            9:       v = 32'd1335087;
            10:      v = 32'd667544;
            11:      v = 32'd333772;
            12:      v = 32'd166886;
            13:      v = 32'd83443;
            14:      v = 32'd41722;
            15:      v = 32'd20861;
            default: v = 32'd683565276 >> idx; // small-angle limit
        endcase
        return v;
    endfunction

    // Same constant rounded to a 'width'-bit signed binary-radian code (width <= 31)
    function automatic logic [31:0] atan_code(input int unsigned idx,
                                              input int unsigned width);
        logic [32:0] r;
        r = {1'b0, atan_brad32(idx)} + (33'd1 << (31 - width));
        return 32'(r >> (32 - width));
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot #(
    parameter int IW = 21,
    parameter int ZW = 22
) (
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam logic signed [ZW-1:0] QUARTER = (ZW)'(1) << (ZW - 2);

    // exact quarter turn towards zero residual
    always_comb begin
        if (!z_i[ZW-1]) begin
            x_o = -y_i;
            y_o = x_i;
            z_o = z_i - QUARTER;
        end else begin
            x_o = y_i;
            y_o = -x_i;
            z_o = z_i + QUARTER;
        end
    end
endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
    parameter int IW = 21,
    parameter int ZW = 22,
    parameter int SW = 4
) (
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic        [SW-1:0] sh,
    input  logic signed [ZW-1:0] step_ang,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    logic signed [IW-1:0] x_sh, y_sh;

    // shared barrel shifters: tangent 2^-sh becomes an arithmetic shift
    assign x_sh = x_i >>> sh;
    assign y_sh = y_i >>> sh;

    // direction chosen by residual sign; never a skipped step
    always_comb begin
        if (!z_i[ZW-1]) begin
            x_o = x_i - y_sh;
            y_o = y_i + x_sh;
            z_o = z_i - step_ang;
        end else begin
            x_o = x_i + y_sh;
            y_o = y_i - x_sh;
            z_o = z_i + step_ang;
        end
    end
endmodule

// File: rtl/cordic_seq.sv
module cordic_seq
    import cordic_rot_pkg::*;
#(
    parameter int ITERS = 16,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          done
);
    cr_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          last;

    assign last = (cnt_q == CW'(ITERS - 1));
    assign load = (st_q == CR_IDLE) && start;
    assign step = (st_q == CR_RUN);
    assign busy = (st_q == CR_RUN);
    assign cnt  = cnt_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CR_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                CR_IDLE: begin
                    if (start) begin
                        st_q  <= CR_RUN;
                        cnt_q <= '0;
                    end
                end
                CR_RUN: begin
                    if (last) begin
                        st_q   <= CR_IDLE;
                        cnt_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= CR_IDLE;
            endcase
        end
    end

    // R3: completion pulse lasts a single cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: completion only follows the final iteration, with busy dropped
    a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(last) && $past(busy)));

    // R4: iterations advance without a gap or restart
    a_r4_run_continuous: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R2: an idle start begins a run at iteration zero
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && cnt == '0));
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
    import cordic_rot_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ANG_W   = 16,
    parameter int ITERS   = 16,
    parameter int GUARD   = 1,
    parameter int FRAC_W  = 4,
    parameter int ZFRAC_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] y_in,
    input  logic signed [ANG_W-1:0]  angle_in,
    output logic                     busy,
    output logic                     done,
    output logic signed [DATA_W:0]   x_out,
    output logic signed [DATA_W:0]   y_out
);
    localparam int OW = DATA_W + GUARD;
    localparam int IW = OW + FRAC_W;
    localparam int ZW = ANG_W + ZFRAC_W;
    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic signed [ZW-1:0] Q_TURN = (ZW)'(1) << (ZW - 2);

    logic          load, step;
    logic [CW-1:0] cnt;

    logic signed [IW-1:0] x_q, y_q, x_ext, y_ext;
    logic signed [IW-1:0] x_pre, y_pre, x_nx, y_nx;
    logic signed [ZW-1:0] z_q, z_ext, z_pre, z_nx, step_ang;

    // arctangent constants, one per iteration
    logic signed [ZW-1:0] atan_lut [ITERS];
    for (genvar k = 0; k < ITERS; k++) begin : g_atan
        assign atan_lut[k] = (ZW)'(atan_code(k, ZW));
    end
    assign step_ang = atan_lut[cnt];

    assign x_ext = (IW)'(x_in) <<< FRAC_W;
    assign y_ext = (IW)'(y_in) <<< FRAC_W;
    assign z_ext = {angle_in, {ZFRAC_W{1'b0}}};

    cordic_seq #(.ITERS(ITERS), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .cnt(cnt),
        .busy(busy), .done(done)
    );

    cordic_prerot #(.IW(IW), .ZW(ZW)) u_prerot (
        .x_i(x_ext), .y_i(y_ext), .z_i(z_ext),
        .x_o(x_pre), .y_o(y_pre), .z_o(z_pre)
    );

    cordic_microrot #(.IW(IW), .ZW(ZW), .SW(CW)) u_micro (
        .x_i(x_q), .y_i(y_q), .z_i(z_q),
        .sh(cnt), .step_ang(step_ang),
        .x_o(x_nx), .y_o(y_nx), .z_o(z_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (load) begin
            x_q <= x_pre;
            y_q <= y_pre;
            z_q <= z_pre;
        end else if (step) begin
            x_q <= x_nx;
            y_q <= y_nx;
            z_q <= z_nx;
        end
    end

    assign x_out = x_q[IW-1:FRAC_W];
    assign y_out = y_q[IW-1:FRAC_W];

    // R7: residual after the quarter turn is within +/- pi/2
    a_r7_residual_quadrant: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (z_q >= -Q_TURN && z_q <= Q_TURN));

    // R8: results stay put while idle without a new command
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));

    // R1: nothing is flagged as finished before a command was taken
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/cordic_rotator_bench.sv
module cordic_rotator_bench;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int IT = 16;
    localparam int OW = DW + 1;
    localparam real PI  = 3.14159265358979;
    localparam real TOL = 5.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [DW-1:0] xi = '0;
    logic signed [DW-1:0] yi = '0;
    logic signed [AW-1:0] ai = '0;
    logic busy, done;
    logic signed [OW-1:0] xo, yo;

    int  n_cmp = 0;
    int  n_bad = 0;
    real gain;

    always #5 clk = ~clk;

    cordic_rotator #(.DATA_W(DW), .ANG_W(AW), .ITERS(IT)) u_cordic_rotator (
        .clk(clk), .rst(rst), .start(start),
        .x_in(xi), .y_in(yi), .angle_in(ai),
        .busy(busy), .done(done), .x_out(xo), .y_out(yo)
    );

    task automatic check_int(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input int act, input real exp);
        real d;
        n_cmp++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%f", tag, act, exp);
        end
    endtask

    // one command; optionally injects a second start mid-run
    task automatic run_op(input int x, input int y, input int a, input bit inject,
                          output int rx, output int ry, output int lat);
        @(negedge clk);
        xi = DW'(x); yi = DW'(y); ai = AW'(a); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        check_int("R2 busy after start", int'(busy), 1);
        while (!done && lat < 200) begin
            if (inject && lat == 5) begin
                xi = DW'(-x); yi = DW'(y + 1000); ai = AW'(a + 9000); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        rx = int'(xo);
        ry = int'(yo);
        check_int("R3 busy low with done", int'(busy), 0);
    endtask

    task automatic verify(input string tag, input int x, input int y, input int a,
                          input int rx, input int ry);
        real th, ex, ey;
        th = real'(a) * PI / 32768.0;
        ex = gain * (real'(x) * $cos(th) - real'(y) * $sin(th));
        ey = gain * (real'(x) * $sin(th) + real'(y) * $cos(th));
        check_near({tag, " x"}, rx, ex);
        check_near({tag, " y"}, ry, ey);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int vx[9] = '{30000, 0, -20000, 12345, 27000, -27000, -32768, 1, 17};
        int vy[9] = '{0, -30000, 15000, -23456, 27000, -27000, 0, 0, 29000};
        int bx[4] = '{27000, 27000, -32768, -27500};
        int by[4] = '{27000, 27000, 0, 27500};
        int ba[4] = '{8192, -24576, -32768, 24576};
        int rx, ry, lat;
        real p;

        gain = 1.0;
        p = 1.0;
        for (int i = 0; i < IT; i++) begin
            gain = gain * $sqrt(1.0 + p);
            p = p / 4.0;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check_int("R1 busy in reset", int'(busy), 0);
        check_int("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1 busy after reset", int'(busy), 0);
        check_int("R1 x_out after reset", int'(xo), 0);
        check_int("R1 y_out after reset", int'(yo), 0);

        // R5 R6: full-circle sweep over several vectors
        for (int off = 0; off < 2; off++) begin
            for (int k = 0; k < 64; k++) begin
                for (int v = 0; v < 9; v++) begin
                    int a;
                    a = -32768 + k * 1024 + off * 517;
                    run_op(vx[v], vy[v], a, 1'b0, rx, ry, lat);
                    check_int("R3 latency", lat, IT);
                    verify("R5 R6 sweep", vx[v], vy[v], a, rx, ry);
                end
            end
        end

        // R9: large magnitudes near the output range limit
        for (int b = 0; b < 4; b++) begin
            run_op(bx[b], by[b], ba[b], 1'b0, rx, ry, lat);
            verify("R9 large vector", bx[b], by[b], ba[b], rx, ry);
        end

        // R3: pulse width; R8: hold while idle
        run_op(-12000, 21000, 12000, 1'b0, rx, ry, lat);
        @(negedge clk);
        check_int("R3 done single cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check_int("R8 x held", int'(xo), rx);
        check_int("R8 y held", int'(yo), ry);

        // R4: start while busy is ignored
        run_op(25000, -8000, -20000, 1'b1, rx, ry, lat);
        check_int("R4 run length unchanged", lat, IT);
        verify("R4 first operands kept", 25000, -8000, -20000, rx, ry);
        @(negedge clk);
        check_int("R4 no second run", int'(busy), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule